// File: doc/BRIEF.md
# Integer ALU with Zero and Overflow Flags

This block is the arithmetic and logic unit of a small 32-bit RISC datapath. It is purely combinational. It takes two operands and a four-bit operation selector, and it returns a 32-bit result together with a zero flag and a signed-overflow flag. Any immediate operand is extended to full width before it reaches this block. Shifts, multiply, divide, instruction decode, the register file and branch resolution all sit outside it.

A single ripple carry chain serves every arithmetic operation. For subtraction the chain adds the bitwise inverse of the second operand and takes a carry of one into bit 0. The signed and unsigned compare operations reuse that subtraction. They produce a 0 or 1 in bit 0 of the result, and bits 31 to 1 are zero.

Top module: `int_alu`

## Requirements
- R1: With op 0x0 (signed add) or op 0x1 (unsigned add), the result is (a + b) mod 2^32.
- R2: With op 0x2 (signed subtract) or op 0x3 (unsigned subtract), the result is (a - b) mod 2^32.
- R3: `ovf` is 1 only under op 0x0 or op 0x2, and then only when the two's complement result cannot represent the true signed sum or difference. Under every other op code `ovf` is 0.
- R4: With op 0x4 the result is a AND b. With 0x5 it is a OR b. With 0x6 it is a XOR b. With 0x7 it is NOT (a OR b).
- R5: With op 0xA, result bit 0 is 1 exactly when a < b as signed 32-bit values, and bits 31..1 are 0. The result stays correct when a - b overflows.
- R6: With op 0xB, result bit 0 is 1 exactly when a < b as unsigned values, and bits 31..1 are 0.
- R7: `zero` is 1 exactly when all 32 result bits are 0, under every op code.
- R8: Op codes 0x8, 0x9, 0xC, 0xD, 0xE and 0xF give a result of 0 and `ovf` of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 32 | First operand |
| b | input | 32 | Second operand, already extended to 32 bits |
| op | input | 4 | Operation selector |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |
| ovf | output | 1 | Signed overflow of signed add or subtract |

## Verification
The checker evaluates its properties only while `a`, `b` and `op` carry no unknown bits. The block has no clock, so the properties are sampled combinationally and assume the inputs are settled. The bench always drives fully known values and samples well after each change. Random op codes span all sixteen codes, so the unused codes are exercised. Operands are drawn from random words, equal pairs and the sign-boundary values, so the overflow and compare corner cases appear often.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

    localparam int DATA_W = 32;
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'h0,
        OP_ADDU = 4'h1,
        OP_SUB  = 4'h2,
        OP_SUBU = 4'h3,
        OP_AND  = 4'h4,
        OP_OR   = 4'h5,
        OP_XOR  = 4'h6,
        OP_NOR  = 4'h7,
        OP_SLT  = 4'hA,
        OP_SLTU = 4'hB
    } alu_op_e;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              zero;
        logic              ovf;
    } alu_out_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             carry_msb,
    output logic             carry_out
);
    logic [WIDTH:0]   chain;
    logic [WIDTH-1:0] b_eff;

    assign chain[0] = sub;

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        assign b_eff[i]     = b[i] ^ sub;
        assign sum[i]       = a[i] ^ b_eff[i] ^ chain[i];
        assign chain[i+1]   = (a[i] & b_eff[i]) | (a[i] & chain[i]) | (b_eff[i] & chain[i]);
    end

    assign carry_msb = chain[WIDTH-1];
    assign carry_out = chain[WIDTH];
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [1:0]       sel,
    output logic [WIDTH-1:0] out
);
    always_comb begin
        case (sel)
            2'd0:    out = a & b;
            2'd1:    out = a | b;
            2'd2:    out = a ^ b;
            default: out = ~(a | b);
        endcase
    end
endmodule

// File: rtl/int_alu.sv
module int_alu
    import int_alu_pkg::*;
(
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [OP_W-1:0]   op,
    output logic [DATA_W-1:0] result,
    output logic              zero,
    output logic              ovf
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] sum_w;
    logic [DATA_W-1:0] logic_w;
    logic              carry_msb_w;
    logic              carry_out_w;
    logic              sign_ovf_w;
    alu_out_t          out_d;

    alu_addsub #(.WIDTH(DATA_W)) u_addsub (
        .a         (a),
        .b         (b),
        .sub       (op[1]),
        .sum       (sum_w),
        .carry_msb (carry_msb_w),
        .carry_out (carry_out_w)
    );

    alu_logic_unit #(.WIDTH(DATA_W)) u_logic (
        .a   (a),
        .b   (b),
        .sel (op[1:0]),
        .out (logic_w)
    );

    assign sign_ovf_w = carry_msb_w ^ carry_out_w;

    always_comb begin
        out_d = '0;
        case (op)
            OP_ADD, OP_SUB: begin
                out_d.value = sum_w;
                out_d.ovf   = sign_ovf_w;
            end
            OP_ADDU, OP_SUBU: out_d.value = sum_w;
            OP_AND, OP_OR, OP_XOR, OP_NOR: out_d.value = logic_w;
            OP_SLT:  out_d.value[0] = sum_w[MSB] ^ sign_ovf_w;
            OP_SLTU: out_d.value[0] = ~carry_out_w;
            default: out_d.value = '0;
        endcase
        out_d.zero = ~|out_d.value;
    end

    assign result = out_d.value;
    assign zero   = out_d.zero;
    assign ovf    = out_d.ovf;
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk
    import int_alu_pkg::*;
(
    input logic [DATA_W-1:0] a,
    input logic [DATA_W-1:0] b,
    input logic [OP_W-1:0]   op,
    input logic [DATA_W-1:0] result,
    input logic              zero,
    input logic              ovf
);
    always_comb begin
        if (!$isunknown({a, b, op})) begin
            // R3: overflow only from signed add or subtract
            assert_ovf_src_R3: assert (!ovf || op == OP_ADD || op == OP_SUB);
            // R8: unused codes give nothing
            if (op inside {4'h8, 4'h9, 4'hC, 4'hD, 4'hE, 4'hF})
                assert_unused_R8: assert (result == '0 && !ovf);
            // R7: equal operands subtract to zero
            if ((op == OP_SUB || op == OP_SUBU) && a == b)
                assert_eq_zero_R7: assert (zero);
            // R6: unsigned compare against native compare
            if (op == OP_SLTU)
                assert_sltu_R6: assert (result == {{(DATA_W-1){1'b0}}, (a < b)});
            // R5: signed compare against native compare
            if (op == OP_SLT)
                assert_slt_R5: assert (result == {{(DATA_W-1){1'b0}}, ($signed(a) < $signed(b))});
        end
    end
endmodule

bind int_alu int_alu_chk u_chk (.*);

// File: tb/int_alu_test.sv
module int_alu_test;
    logic        clk = 1'b0;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic [3:0]  op = '0;
    logic [31:0] result;
    logic        zero;
    logic        ovf;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    int_alu uut (.a(a), .b(b), .op(op), .result(result), .zero(zero), .ovf(ovf));

    function automatic logic [31:0] exp_result(logic [31:0] x, logic [31:0] y, logic [3:0] o);
        case (o)
            4'h0, 4'h1: return x + y;
            4'h2, 4'h3: return x - y;
            4'h4: return x & y;
            4'h5: return x | y;
            4'h6: return x ^ y;
            4'h7: return ~(x | y);
            4'hA: return {31'b0, ($signed(x) < $signed(y))};
            4'hB: return {31'b0, (x < y)};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic exp_ovf(logic [31:0] x, logic [31:0] y, logic [3:0] o);
        logic [31:0] r;
        r = exp_result(x, y, o);
        if (o == 4'h0) return (x[31] == y[31]) && (r[31] != x[31]);
        if (o == 4'h2) return (x[31] != y[31]) && (r[31] != x[31]);
        return 1'b0;
    endfunction

    function automatic string res_tag(logic [3:0] o);
        case (o)
            4'h0, 4'h1: return "R1";
            4'h2, 4'h3: return "R2";
            4'h4, 4'h5, 4'h6, 4'h7: return "R4";
            4'hA: return "R5";
            4'hB: return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s a=%h b=%h op=%h actual=%h expected=%h", tag, a, b, op, act, exp);
        end
    endtask

    task automatic apply(logic [31:0] x, logic [31:0] y, logic [3:0] o);
        logic [31:0] er;
        @(negedge clk);
        a = x; b = y; op = o;
        #5;
        er = exp_result(x, y, o);
        check(res_tag(o), result, er);
        check("R7", {31'b0, zero}, {31'b0, (er == 32'h0)});
        check((o inside {4'h8, 4'h9, 4'hC, 4'hD, 4'hE, 4'hF}) ? "R8" : "R3",
              {31'b0, ovf}, {31'b0, exp_ovf(x, y, o)});
    endtask

    function automatic logic [31:0] pick_operand(logic [31:0] other);
        case ($urandom % 6)
            0: return 32'h8000_0000;
            1: return 32'h7FFF_FFFF;
            2: return other;
            3: return 32'hFFFF_FFFF;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        void'($urandom(32'h5EED_0A1C));
        #3;
        // reset-free start: all-zero inputs give zero result with add (R1, R7)
        check("R1", result, 32'h0);
        check("R7", {31'b0, zero}, 32'h1);
        // directed corners
        apply(32'h8000_0000, 32'h1, 4'h2);          // R2/R3 overflow on subtract
        apply(32'h8000_0000, 32'h1, 4'h3);          // R3 suppressed for unsigned
        apply(32'h7FFF_FFFF, 32'h1, 4'h0);          // R3 overflow on add
        apply(32'h7FFF_FFFF, 32'h1, 4'h1);          // R1 unsigned, no flag
        apply(32'h1234_5678, 32'h1234_5678, 4'h2);  // R7 equal operands
        apply(32'h1234_5678, 32'h1234_5678, 4'hA);  // R5 equal
        apply(32'h1234_5678, 32'h1234_5678, 4'hB);  // R6 equal
        apply(32'h8000_0000, 32'h7FFF_FFFF, 4'hA);  // R5 overflowing compare
        apply(32'h7FFF_FFFF, 32'h8000_0000, 4'hA);  // R5 overflowing compare
        apply(32'h8000_0000, 32'h7FFF_FFFF, 4'hB);  // R6
        apply(32'h0000_0001, 32'hFFFF_FFFF, 4'hB);  // R6
        apply(32'h0000_3C00, 32'h0000_0D00, 4'h4);  // R4
        apply(32'h0000_3C00, 32'h0000_0D00, 4'h5);  // R4
        apply(32'h0000_3C00, 32'h0000_0D00, 4'h6);  // R4
        apply(32'h0000_3C00, 32'h0000_0D00, 4'h7);  // R4
        apply(32'h0, 32'h0, 4'h7);                  // R4/R7 nor of zeros
        for (int u = 8; u < 16; u++)
            if (u != 10 && u != 11) apply(32'hFFFF_FFFF, 32'h1, u[3:0]);  // R8
        for (int k = 0; k < 4000; k++) begin
            logic [31:0] x;
            x = pick_operand($urandom);
            apply(x, pick_operand(x), 4'($urandom % 16));
        end
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule